// File: doc/BRIEF.md
# Multi-Format Page Table Walker

This block turns a virtual address into a translation record by reading page table entries from memory one level at a time. A request carries the virtual address, the root table field, a paging format (four-level 64-bit tables, three-level tables with a small pointer table on top, or two-level 32-bit tables), a large-page enable for the two-level format, a no-execute enforcement enable and the access type. The walker reads one entry per level over a valid/ready request channel. It then waits for a single response before it moves on.

Each permission level narrows the writable and user rights, and a directory entry with its size bit set can stop the walk early with a large page. The walk ends with a one-cycle fill pulse for a translation cache or a one-cycle fault pulse. The fill carries the frame base, the page size, the global, uncacheable and attribute-index bits, the writable and user rights and the no-execute flag. The fault carries the address, whether the entry was present and the access type. Entry format: P bit 0, W bit 1, U bit 2, cache-disable bit 4, size bit 7, global bit 8, no-execute bit 63 (8-byte entries only).

Top module: `ptwalk`

## Requirements
- R1: A request is taken only while `req_ready` is high, which holds only while no walk is running; the walker has at most one read in flight, and `mem_req_addr` stays stable while `mem_req_valid` waits for `mem_req_ready`.
- R2: With `req_mode`=2 (four-level), the first read is at `req_root[39:0]`<<12 plus vaddr[47:39]*8; each later read is at entry bits 51:12 shifted left by 12, plus that level's 9-bit index (vaddr[38:30], [29:21], [20:12]) times 8.
- R3: With `req_mode`=1 (three-level), the first read is at `req_root`<<5 plus vaddr[31:30]*8. With `req_mode`=0 (two-level), it is at `req_root[19:0]`<<12 plus vaddr[31:22]*4, the next at entry bits 31:12 shifted left by 12 plus vaddr[21:12]*4, and only `mem_rsp_data[31:0]` is used.
- R4: The writable and user outputs are the AND of the W and U bits of every permission level; the top pointer level of the three-level format contributes nothing. The no-execute output is bit 63 of the first permission level.
- R5: A walk faults at the first entry with P clear (`fault_present`=0), or with bit 63 set on a fetch while enforcement is on (`fault_present`=1); `fault_vaddr` is the request address.
- R6: `fault_acc` reports the access type (0 read, 1 write, 2 fetch), except that a fetch without enforcement is reported as 0.
- R7: In the four- and three-level formats, a directory entry with bit 7 set ends the walk as a 2 MB page (`fill_size`=1) whose base is entry bits 51:21, with the attribute index from bit 12.
- R8: A last-level entry gives a 4 KB page (`fill_size`=0) with the base from entry bits 51:12 (bits 31:12 in the two-level format) and the attribute index from bit 7.
- R9: In the two-level format with `req_pse` high, a directory entry with bit 7 set gives a 4 MB page (`fill_size`=2) with base bits 31:22 from entry bits 31:22, base bits 39:32 from entry bits 20:13 and the attribute index from bit 12; with `req_pse` low, bit 7 is ignored.
- R10: `fill_vaddr` is the request address aligned down to the page size, and `fill_global` and `fill_uncache` are bits 8 and 4 of the ending entry.
- R11: Exactly one of `fill_valid` and `fault_valid` pulses high for a single cycle, in the cycle after the final response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 48 | Virtual address to translate |
| req_mode | input | 2 | 0 two-level, 1 three-level, 2 four-level |
| req_root | input | 52 | Root table field |
| req_pse | input | 1 | Enable 4 MB pages in two-level format |
| req_nxe | input | 1 | Enforce no-execute on fetches |
| req_acc | input | 2 | 0 read, 1 write, 2 fetch |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry data |
| fill_valid | output | 1 | Translation record pulse |
| fill_vaddr | output | 48 | Page-aligned virtual address |
| fill_pa | output | 52 | Physical page base |
| fill_size | output | 2 | 0 4 KB, 1 2 MB, 2 4 MB |
| fill_global | output | 1 | Global bit of the ending entry |
| fill_uncache | output | 1 | Cache-disable bit of the ending entry |
| fill_pat | output | 1 | Attribute-index bit |
| fill_write | output | 1 | Accumulated writable right |
| fill_user | output | 1 | Accumulated user right |
| fill_nx | output | 1 | No-execute flag |
| fault_valid | output | 1 | Fault pulse |
| fault_vaddr | output | 48 | Faulting virtual address |
| fault_present | output | 1 | Faulting entry was present |
| fault_acc | output | 2 | Reported access type |

## Verification
The assertions take for granted that the memory returns exactly one response per accepted read and never raises `mem_rsp_valid` unless a read has been accepted. They also take for granted that the memory leaves `mem_req_ready` low while no read is offered. The bench's memory model answers only after a handshake and asserts `mem_rsp_valid` for one cycle in the cycle after it. It holds `mem_req_ready` back for a few cycles in one scenario, so the held-address check sees real waiting. A request raised while a walk runs is applied only while `req_ready` is low, so it exercises the guard without starting a second walk.

// File: rtl/ptwalk_pkg.sv
package ptwalk_pkg;
  localparam int VA_W  = 48;
  localparam int PA_W  = 52;
  localparam int PTE_W = 64;
  localparam int IDX_W = 10;
  localparam int LVL_W = 2;
  localparam int PG_SH = 12;

  localparam int B_P   = 0;
  localparam int B_W   = 1;
  localparam int B_U   = 2;
  localparam int B_PCD = 4;
  localparam int B_PS  = 7;
  localparam int B_G   = 8;
  localparam int B_NX  = 63;
  localparam int B_PAT_SMALL = 7;
  localparam int B_PAT_LARGE = 12;

  typedef enum logic [1:0] {PM_TWO = 2'd0, PM_THREE = 2'd1, PM_FOUR = 2'd2} pmode_e;
  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [1:0] {PG_4K = 2'd0, PG_2M = 2'd1, PG_4M = 2'd2} pgsz_e;

  function automatic pmode_e f_norm_mode(input logic [1:0] m);
    return (m == 2'd3) ? PM_TWO : pmode_e'(m);
  endfunction

  function automatic logic [LVL_W-1:0] f_start_lvl(input pmode_e m);
    case (m)
      PM_FOUR:  return 2'd3;
      PM_THREE: return 2'd2;
      default:  return 2'd1;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] f_index(input pmode_e m, input logic [LVL_W-1:0] lvl,
                                               input logic [VA_W-1:0] va);
    logic [IDX_W-1:0] r;
    case (m)
      PM_FOUR:  r = {1'b0, va[PG_SH + 9*lvl +: 9]};
      PM_THREE: r = (lvl == 2'd2) ? {8'b0, va[31:30]} : {1'b0, va[PG_SH + 9*lvl[0] +: 9]};
      default:  r = va[PG_SH + 10*lvl[0] +: 10];
    endcase
    return r;
  endfunction

  function automatic logic [PA_W-1:0] f_entry_addr(input pmode_e m, input logic [PA_W-1:0] base,
                                                   input logic [IDX_W-1:0] idx);
    if (m == PM_TWO) return base + {{(PA_W-IDX_W-2){1'b0}}, idx, 2'b00};
    return base + {{(PA_W-IDX_W-3){1'b0}}, idx, 3'b000};
  endfunction

  function automatic logic [PA_W-1:0] f_root_base(input pmode_e m, input logic [PA_W-1:0] root);
    case (m)
      PM_FOUR:  return {root[PA_W-PG_SH-1:0], {PG_SH{1'b0}}};
      PM_THREE: return {root[PA_W-6:0], 5'b0};
      default:  return {20'b0, root[19:0], {PG_SH{1'b0}}};
    endcase
  endfunction

  function automatic logic [VA_W-1:0] f_page_mask(input pgsz_e sz);
    case (sz)
      PG_2M:   return VA_W'(48'h1F_FFFF);
      PG_4M:   return VA_W'(48'h3F_FFFF);
      default: return VA_W'(48'hFFF);
    endcase
  endfunction

  function automatic logic [VA_W-1:0] f_align(input logic [VA_W-1:0] va, input pgsz_e sz);
    return va & ~f_page_mask(sz);
  endfunction

  function automatic acc_e f_report_acc(input acc_e a, input logic nxe);
    return (a == ACC_FETCH && !nxe) ? ACC_READ : a;
  endfunction
endpackage

// File: rtl/ptwalk_addr.sv
module ptwalk_addr
  import ptwalk_pkg::*;
(
  input  pmode_e           mode,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VA_W-1:0]  va,
  input  logic [PA_W-1:0]  base,
  output logic [PA_W-1:0]  addr
);
  logic [IDX_W-1:0] idx;
  assign idx  = f_index(mode, lvl, va);
  assign addr = f_entry_addr(mode, base, idx);
endmodule

// File: rtl/ptwalk_decode.sv
module ptwalk_decode
  import ptwalk_pkg::*;
(
  input  pmode_e           mode,
  input  logic [LVL_W-1:0] lvl,
  input  logic             pse,
  input  logic             nxe,
  input  acc_e             acc,
  input  logic [PTE_W-1:0] rsp,
  output logic             e_p,
  output logic             e_w,
  output logic             e_u,
  output logic             e_nx,
  output logic             perm_lvl,
  output logic             top_perm,
  output logic             fault,
  output logic             leaf,
  output pgsz_e            leaf_sz,
  output logic [PA_W-1:0]  leaf_pa,
  output logic             leaf_pat,
  output logic             leaf_g,
  output logic             leaf_uc,
  output logic [PA_W-1:0]  next_base
);
  logic [PTE_W-1:0] pte;
  logic             nx_hit;

  assign pte      = (mode == PM_TWO) ? {32'b0, rsp[31:0]} : rsp;
  assign e_p      = pte[B_P];
  assign e_w      = pte[B_W];
  assign e_u      = pte[B_U];
  assign e_nx     = (mode != PM_TWO) && pte[B_NX];
  assign perm_lvl = !(mode == PM_THREE && lvl == 2'd2);
  assign top_perm = (mode == PM_FOUR) ? (lvl == 2'd3) : (lvl == 2'd1);
  assign nx_hit   = perm_lvl && e_nx && acc == ACC_FETCH && nxe;
  assign fault    = !e_p || nx_hit;
  assign leaf     = (lvl == 2'd0) ||
                    (lvl == 2'd1 && pte[B_PS] && (mode != PM_TWO || pse));

  always_comb begin
    if (lvl == 2'd0) leaf_sz = PG_4K;
    else if (mode == PM_TWO) leaf_sz = PG_4M;
    else leaf_sz = PG_2M;
  end

  always_comb begin
    case (leaf_sz)
      PG_2M:   leaf_pa = {pte[51:21], 21'b0};
      PG_4M:   leaf_pa = {12'b0, pte[20:13], pte[31:22], 22'b0};
      default: leaf_pa = (mode == PM_TWO) ? {20'b0, pte[31:12], 12'b0} : {pte[51:12], 12'b0};
    endcase
  end

  assign leaf_pat  = (lvl == 2'd0) ? pte[B_PAT_SMALL] : pte[B_PAT_LARGE];
  assign leaf_g    = pte[B_G];
  assign leaf_uc   = pte[B_PCD];
  assign next_base = (mode == PM_TWO) ? {20'b0, pte[31:12], 12'b0} : {pte[51:12], 12'b0};
endmodule

// File: rtl/ptwalk.sv
module ptwalk
  import ptwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [47:0] req_vaddr,
  input  logic [1:0]  req_mode,
  input  logic [51:0] req_root,
  input  logic        req_pse,
  input  logic        req_nxe,
  input  logic [1:0]  req_acc,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [51:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        fill_valid,
  output logic [47:0] fill_vaddr,
  output logic [51:0] fill_pa,
  output logic [1:0]  fill_size,
  output logic        fill_global,
  output logic        fill_uncache,
  output logic        fill_pat,
  output logic        fill_write,
  output logic        fill_user,
  output logic        fill_nx,
  output logic        fault_valid,
  output logic [47:0] fault_vaddr,
  output logic        fault_present,
  output logic [1:0]  fault_acc
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

  st_e              st;
  pmode_e           mode_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VA_W-1:0]  va_q;
  logic             pse_q, nxe_q;
  acc_e             acc_q;
  logic [PA_W-1:0]  addr_q;
  logic             w_q, u_q, nx_q;

  pmode_e           req_m;
  logic [LVL_W-1:0] start_lvl, lvl_nxt;
  logic [PA_W-1:0]  start_base, start_addr, step_addr;

  logic             d_p, d_w, d_u, d_nx, d_perm, d_top, d_fault, d_leaf;
  logic             d_pat, d_g, d_uc;
  pgsz_e            d_sz;
  logic [PA_W-1:0]  d_pa, d_next;
  logic             w_nxt, u_nxt, nx_nxt;

  // named events for the checker
  logic ev_accept, ev_sent, ev_rsp, ev_fault, ev_leaf, ev_step;

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_ISSUE);
  assign mem_req_addr  = addr_q;

  assign req_m      = f_norm_mode(req_mode);
  assign start_lvl  = f_start_lvl(req_m);
  assign start_base = f_root_base(req_m, req_root);
  assign lvl_nxt    = lvl_q - 2'd1;

  ptwalk_addr u_start_addr (
    .mode(req_m), .lvl(start_lvl), .va(req_vaddr), .base(start_base), .addr(start_addr)
  );

  ptwalk_addr u_step_addr (
    .mode(mode_q), .lvl(lvl_nxt), .va(va_q), .base(d_next), .addr(step_addr)
  );

  ptwalk_decode u_decode (
    .mode(mode_q), .lvl(lvl_q), .pse(pse_q), .nxe(nxe_q), .acc(acc_q), .rsp(mem_rsp_data),
    .e_p(d_p), .e_w(d_w), .e_u(d_u), .e_nx(d_nx), .perm_lvl(d_perm), .top_perm(d_top),
    .fault(d_fault), .leaf(d_leaf), .leaf_sz(d_sz), .leaf_pa(d_pa), .leaf_pat(d_pat),
    .leaf_g(d_g), .leaf_uc(d_uc), .next_base(d_next)
  );

  assign ev_accept = req_valid && req_ready;
  assign ev_sent   = mem_req_valid && mem_req_ready;
  assign ev_rsp    = (st == ST_WAIT) && mem_rsp_valid;
  assign ev_fault  = ev_rsp && d_fault;
  assign ev_leaf   = ev_rsp && !d_fault && d_leaf;
  assign ev_step   = ev_rsp && !d_fault && !d_leaf;

  assign w_nxt  = d_perm ? (w_q & d_w) : w_q;
  assign u_nxt  = d_perm ? (u_q & d_u) : u_q;
  assign nx_nxt = d_top ? d_nx : nx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mode_q <= PM_TWO;
      lvl_q  <= '0;
      va_q   <= '0;
      pse_q  <= 1'b0;
      nxe_q  <= 1'b0;
      acc_q  <= ACC_READ;
      addr_q <= '0;
      w_q    <= 1'b1;
      u_q    <= 1'b1;
      nx_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (ev_accept) begin
          st     <= ST_ISSUE;
          mode_q <= req_m;
          lvl_q  <= start_lvl;
          va_q   <= req_vaddr;
          pse_q  <= req_pse;
          nxe_q  <= req_nxe;
          acc_q  <= acc_e'(req_acc);
          addr_q <= start_addr;
          w_q    <= 1'b1;
          u_q    <= 1'b1;
          nx_q   <= 1'b0;
        end
        ST_ISSUE: if (ev_sent) st <= ST_WAIT;
        ST_WAIT: if (ev_rsp) begin
          w_q  <= w_nxt;
          u_q  <= u_nxt;
          nx_q <= nx_nxt;
          if (ev_step) begin
            st     <= ST_ISSUE;
            lvl_q  <= lvl_nxt;
            addr_q <= step_addr;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_valid    <= 1'b0;
      fill_vaddr    <= '0;
      fill_pa       <= '0;
      fill_size     <= PG_4K;
      fill_global   <= 1'b0;
      fill_uncache  <= 1'b0;
      fill_pat      <= 1'b0;
      fill_write    <= 1'b0;
      fill_user     <= 1'b0;
      fill_nx       <= 1'b0;
      fault_valid   <= 1'b0;
      fault_vaddr   <= '0;
      fault_present <= 1'b0;
      fault_acc     <= ACC_READ;
    end else begin
      fill_valid  <= ev_leaf;
      fault_valid <= ev_fault;
      if (ev_leaf) begin
        fill_vaddr   <= f_align(va_q, d_sz);
        fill_pa      <= d_pa;
        fill_size    <= d_sz;
        fill_global  <= d_g;
        fill_uncache <= d_uc;
        fill_pat     <= d_pat;
        fill_write   <= w_nxt;
        fill_user    <= u_nxt;
        fill_nx      <= nx_nxt;
      end
      if (ev_fault) begin
        fault_vaddr   <= va_q;
        fault_present <= d_p;
        fault_acc     <= f_report_acc(acc_q, nxe_q);
      end
    end
  end
endmodule

// File: rtl/ptwalk_chk.sv
module ptwalk_chk
  import ptwalk_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [51:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        fill_valid,
  input logic [47:0] fill_vaddr,
  input logic [51:0] fill_pa,
  input logic [1:0]  fill_size,
  input logic        fault_valid,
  input logic [1:0]  fault_acc,
  input logic        nxe_q,
  input logic        ev_step
);
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R1
  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R1
  AST_STEP_REISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> mem_req_valid && !req_ready); // R2
  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[1:0] == 2'b00); // R3
  AST_FETCH_AS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && fault_acc == 2'd2 |-> nxe_q); // R6
  AST_LARGE_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_size == 2'd1 |-> fill_pa[20:0] == '0); // R7
  AST_FILL_VA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (fill_size == 2'd0 && fill_vaddr[11:0] == '0) ||
                   (fill_size == 2'd1 && fill_vaddr[20:0] == '0) ||
                   (fill_size == 2'd2 && fill_vaddr[21:0] == '0)); // R10
  AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fault_valid)); // R11
  AST_RESULT_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid || fault_valid |-> $past(mem_rsp_valid)); // R11
  AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid); // R11
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid); // R11
endmodule

bind ptwalk ptwalk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_pa(fill_pa), .fill_size(fill_size),
  .fault_valid(fault_valid), .fault_acc(fault_acc), .nxe_q(nxe_q), .ev_step(ev_step)
);

// File: tb/sim_ptwalk.sv
`timescale 1ns/1ps
module sim_ptwalk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_vaddr = '0;
  logic [1:0]  req_mode = '0;
  logic [51:0] req_root = '0;
  logic        req_pse = 1'b0;
  logic        req_nxe = 1'b0;
  logic [1:0]  req_acc = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        fill_valid, fill_global, fill_uncache, fill_pat, fill_write, fill_user, fill_nx;
  logic [47:0] fill_vaddr, fault_vaddr;
  logic [51:0] fill_pa;
  logic [1:0]  fill_size, fault_acc;
  logic        fault_valid, fault_present;

  ptwalk u0 (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [63:0] mem [logic [51:0]];
  int          stall = 0;
  int          nrd = 0;
  logic [51:0] rd_addr [8];
  int          hold_err = 0, ready_err = 0;
  bit          narrow = 0;

  // captured results
  bit          g_fill, g_fault;
  logic [47:0] g_fva, g_fltva;
  logic [51:0] g_pa;
  logic [1:0]  g_sz, g_facc;
  logic        g_glb, g_uc, g_pat, g_w, g_u, g_nx, g_pres;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put64(input logic [51:0] a, input logic [63:0] v);
    mem[{a[51:3], 3'b0}] = v;
  endtask

  task automatic put32(input logic [51:0] a, input logic [31:0] v);
    logic [63:0] w;
    logic [51:0] k;
    k = {a[51:3], 3'b0};
    w = mem.exists(k) ? mem[k] : 64'h0;
    if (a[2]) w[63:32] = v; else w[31:0] = v;
    mem[k] = w;
  endtask

  function automatic logic [63:0] mem_read(input logic [51:0] a);
    logic [63:0] w;
    logic [51:0] k;
    k = {a[51:3], 3'b0};
    w = mem.exists(k) ? mem[k] : 64'h0;
    if (narrow) return {32'hFFFF_FFFF, a[2] ? w[63:32] : w[31:0]};
    return w;
  endfunction

  // memory responder: one read at a time, response in the cycle after the handshake
  initial begin
    logic [51:0] a;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_valid) begin
        a = mem_req_addr;
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          if (!mem_req_valid || mem_req_addr !== a) hold_err++;
          if (req_ready) ready_err++;
        end
        mem_req_ready = 1'b1;
        if (nrd < 8) rd_addr[nrd] = a;
        nrd++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_data  = mem_read(a);
        mem_rsp_valid = 1'b1;
      end
    end
  end

  task automatic do_walk(input logic [1:0] m, input logic [51:0] root, input logic [47:0] va,
                         input logic pse, input logic nxe, input logic [1:0] acc,
                         input int st, input bit poke);
    nrd = 0; hold_err = 0; ready_err = 0; stall = st;
    narrow = (m == 2'd0);
    @(negedge clk);
    req_mode = m; req_root = root; req_vaddr = va; req_pse = pse; req_nxe = nxe; req_acc = acc;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      req_vaddr = 48'hFFFF_FFFF_FFFF; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      req_vaddr = va;
    end
    for (int k = 0; k < 400 && !(fill_valid || fault_valid); k++) @(negedge clk);
    g_fill = fill_valid; g_fault = fault_valid;
    g_fva = fill_vaddr; g_pa = fill_pa; g_sz = fill_size; g_glb = fill_global;
    g_uc = fill_uncache; g_pat = fill_pat; g_w = fill_write; g_u = fill_user; g_nx = fill_nx;
    g_fltva = fault_vaddr; g_pres = fault_present; g_facc = fault_acc;
    @(negedge clk);
    check("R11 result is a single-cycle pulse", {62'b0, fill_valid, fault_valid}, 64'h0);
  endtask

  localparam logic [47:0] VA_L = 48'h0080_8060_4123;

  task automatic t_reset;
    check("R1 reset ready", {63'b0, req_ready}, 64'h1);
    check("R1 reset no read", {63'b0, mem_req_valid}, 64'h0);
    check("R11 reset no result", {62'b0, fill_valid, fault_valid}, 64'h0);
  endtask

  task automatic t_four_small;
    mem.delete();
    put64(52'h1008, 64'h2007);
    put64(52'h2010, 64'h3007);
    put64(52'h3018, 64'h4003);
    put64(52'h4020, 64'hABCD_E197);
    do_walk(2'd2, 52'h1, VA_L, 1'b0, 1'b1, 2'd0, 3, 1'b1);
    check("R1 address held during stall", hold_err, 0);
    check("R1 ready low while busy", ready_err, 0);
    check("R1 busy request ignored, reads", nrd, 4);
    check("R2 read 0", rd_addr[0], 52'h1008);
    check("R2 read 1", rd_addr[1], 52'h2010);
    check("R2 read 2", rd_addr[2], 52'h3018);
    check("R2 read 3", rd_addr[3], 52'h4020);
    check("R11 fill only", {62'b0, g_fill, g_fault}, 64'h2);
    check("R8 4K base", g_pa, 52'hABCD_E000);
    check("R8 4K size", g_sz, 2'd0);
    check("R8 attribute bit 7", g_pat, 1'b1);
    check("R10 aligned vaddr", g_fva, 48'h0080_8060_4000);
    check("R10 global and uncache", {g_glb, g_uc}, 2'b11);
    check("R4 write kept, user cleared", {g_w, g_u, g_nx}, 3'b100);
  endtask

  task automatic t_four_large;
    mem.delete();
    put64(52'h1008, 64'h8000_0000_0000_2007);
    put64(52'h2010, 64'h3007);
    put64(52'h3018, 64'h4020_1087);
    do_walk(2'd2, 52'h1, VA_L, 1'b0, 1'b1, 2'd0, 0, 1'b0);
    check("R7 reads", nrd, 3);
    check("R11 fill only", {62'b0, g_fill, g_fault}, 64'h2);
    check("R7 2M base", g_pa, 52'h4020_0000);
    check("R7 2M size", g_sz, 2'd1);
    check("R7 attribute bit 12", g_pat, 1'b1);
    check("R10 2M aligned vaddr", g_fva, 48'h0080_8060_0000);
    check("R4 nx from top level", {g_w, g_u, g_nx}, 3'b111);
  endtask

  task automatic t_three_small;
    mem.delete();
    put64(52'h1008, 64'h2001);
    put64(52'h2028, 64'h3003);
    put64(52'h3030, 64'h5007);
    do_walk(2'd1, 52'h80, 48'h40A0_6055, 1'b0, 1'b0, 2'd1, 0, 1'b0);
    check("R3 three-level first read", rd_addr[0], 52'h1008);
    check("R3 three-level second read", rd_addr[1], 52'h2028);
    check("R3 three-level third read", rd_addr[2], 52'h3030);
    check("R11 fill only", {62'b0, g_fill, g_fault}, 64'h2);
    check("R8 three-level base", g_pa, 52'h5000);
    check("R4 pointer level excluded, user ANDed", {g_w, g_u, g_nx}, 3'b100);
    check("R10 three-level vaddr", g_fva, 48'h40A0_6000);
  endtask

  task automatic t_two_small;
    mem.delete();
    put32(52'h100C, 32'h0000_2087);
    put32(52'h2014, 32'h9ABC_D197);
    do_walk(2'd0, 52'h1, 48'h00C0_5007, 1'b0, 1'b0, 2'd0, 0, 1'b0);
    check("R9 size bit ignored without enable, reads", nrd, 2);
    check("R3 two-level first read", rd_addr[0], 52'h100C);
    check("R3 two-level second read", rd_addr[1], 52'h2014);
    check("R8 two-level base", g_pa, 52'h9ABC_D000);
    check("R8 two-level size and attribute", {g_sz, g_pat}, 3'b001);
    check("R10 two-level vaddr and bits", {g_fva, g_glb, g_uc}, {48'h00C0_5000, 2'b11});
    check("R4 two-level rights", {g_w, g_u, g_nx}, 3'b110);
  endtask

  task automatic t_two_large;
    mem.delete();
    put32(52'h100C, 32'hB002_5087);
    do_walk(2'd0, 52'h1, 48'h00C0_5007, 1'b1, 1'b0, 2'd0, 0, 1'b0);
    check("R9 one read", nrd, 1);
    check("R11 fill only", {62'b0, g_fill, g_fault}, 64'h2);
    check("R9 4M base", g_pa, 52'h12_B000_0000);
    check("R9 4M size and attribute", {g_sz, g_pat}, 3'b101);
    check("R10 4M vaddr", g_fva, 48'h00C0_0000);
  endtask

  task automatic t_fault_absent;
    mem.delete();
    put64(52'h1008, 64'h2007);
    put64(52'h2010, 64'h3006);
    do_walk(2'd2, 52'h1, VA_L, 1'b0, 1'b1, 2'd1, 0, 1'b0);
    check("R5 stops at absent entry", nrd, 2);
    check("R11 fault only", {62'b0, g_fill, g_fault}, 64'h1);
    check("R5 not present", g_pres, 1'b0);
    check("R5 fault vaddr", g_fltva, VA_L);
    check("R6 write reported", g_facc, 2'd1);
  endtask

  task automatic t_fault_nx;
    mem.delete();
    put64(52'h1008, 64'h8000_0000_0000_2007);
    do_walk(2'd2, 52'h1, VA_L, 1'b0, 1'b1, 2'd2, 0, 1'b0);
    check("R5 nx fault at first read", nrd, 1);
    check("R11 fault only", {62'b0, g_fill, g_fault}, 64'h1);
    check("R5 nx fault present", g_pres, 1'b1);
    check("R6 fetch reported", g_facc, 2'd2);
  endtask

  task automatic t_fetch_no_enforce;
    mem.delete();
    put64(52'h1008, 64'h8000_0000_0000_2007);
    put64(52'h2010, 64'h3006);
    do_walk(2'd2, 52'h1, VA_L, 1'b0, 1'b0, 2'd2, 0, 1'b0);
    check("R5 nx ignored without enforcement", nrd, 2);
    check("R5 absent fault", {g_fault, g_pres}, 2'b10);
    check("R6 fetch reported as read", g_facc, 2'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_four_small();
    t_four_large();
    t_three_small();
    t_two_small();
    t_two_large();
    t_fault_absent();
    t_fault_nx();
    t_fetch_no_enforce();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule